// File: doc/BRIEF.md
# Three-Operand Integer Execute Stage

This block is the combinational execute step of a simple 32-bit load/store processor pipeline. Each cycle it is handed one already-fetched 32-bit instruction word together with the two source register values that the register file read for it. From these it forms a 32-bit result and the index of the register that should receive it. It also raises a write-enable for the write-back stage. Every supported instruction names one destination and two sources. The second source is either the second register value or a 16-bit constant carried in the instruction word.

Two word layouts are decoded, both 32 bits wide. The register form holds, from the top bit down: a 6-bit opcode at [31:26], first source index [25:21], second source index [20:16], destination index [15:11], a 5-bit shift count [10:6] and a 6-bit function code [5:0]. The immediate form keeps the opcode and both register index fields in the same places and puts a 16-bit constant in [15:0]. Encodings outside the supported set are flagged on an illegal-instruction output, and write-back is then blocked. The register file, memory access and control flow are handled elsewhere.

Top module: `exu_core`

## Requirements
- R1: Register form, opcode 0x00 with function 0x20, returns the sum of the two register operands modulo 2^32, with no overflow indication.
- R2: Register form, opcode 0x00 with function 0x22, returns the first operand minus the second operand modulo 2^32.
- R3: Register form, opcode 0x00, with function 0x24 returns the bitwise AND of the operands and with function 0x25 returns the bitwise OR.
- R4: Register form, opcode 0x00 with function 0x27, returns the bitwise NOR of the operands. NOR against zero gives the bitwise complement.
- R5: Register form, opcode 0x00 with function 0x00, shifts the second register operand left by the count in bits [10:6] and fills with zeros.
- R6: Register form, opcode 0x00 with function 0x02, shifts the second register operand right by the count in bits [10:6] and fills with zeros, including when the top bit is set.
- R7: Immediate opcode 0x08 adds the sign-extended 16-bit constant to the first register operand, modulo 2^32.
- R8: Immediate opcodes 0x0C (AND) and 0x0D (OR) combine the first register operand with the zero-extended 16-bit constant.
- R9: Immediate opcode 0x0A returns 1 when the first register operand, read as signed two's complement, is below the sign-extended constant, and returns 0 otherwise (equal included).
- R10: The destination index is bits [15:11] for the register form and bits [20:16] for the immediate forms.
- R11: When the destination index is 0, write-enable is low, while the result is still produced.
- R12: An opcode outside {0x00, 0x08, 0x0A, 0x0C, 0x0D}, or a function code outside {0x00, 0x02, 0x20, 0x22, 0x24, 0x25, 0x27} under opcode 0x00, drives illegal high, write-enable low and the result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to execute |
| src_a_i | input | 32 | Value of the register named in bits [25:21] |
| src_b_i | input | 32 | Value of the register named in bits [20:16] |
| result_o | output | 32 | Computed result |
| dst_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back enable |
| illegal_o | output | 1 | Unsupported encoding flag |

## Verification
The embedded checks assume that the instruction word and both operand values are fully settled before they are evaluated. For that reason they are immediate checks on combinational outputs. They are not relations across clock cycles. The bench honours this by changing all three inputs together, one time unit after a clock edge, and only comparing outputs at the opposite edge. Operand values were picked so that the extremes in the shift, sign-extension and signed-compare checks are reached: all-ones, the top bit alone, and equal values.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int SH_W   = $clog2(XLEN);

  localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;

  localparam logic [FN_W-1:0] FN_SLL = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL = 6'h02;
  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_NOR = 6'h27;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    alu_op_e            op;
    logic               use_imm;
    logic               sign_ext;
    logic               legal;
    logic [RIDX_W-1:0]  dst;
  } exu_ctl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]   funct_i,
  input  logic [RIDX_W-1:0] rt_i,
  input  logic [RIDX_W-1:0] rd_i,
  output exu_ctl_t          ctl_o
);
  logic reg_form;

  always_comb begin
    ctl_o          = '0;
    ctl_o.op       = ALU_ADD;
    ctl_o.legal    = 1'b1;
    reg_form       = 1'b0;
    unique case (opcode_i)
      OPC_REG: begin
        reg_form = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctl_o.op = ALU_ADD;
          FN_SUB:  ctl_o.op = ALU_SUB;
          FN_AND:  ctl_o.op = ALU_AND;
          FN_OR:   ctl_o.op = ALU_OR;
          FN_NOR:  ctl_o.op = ALU_NOR;
          FN_SLL:  ctl_o.op = ALU_SLL;
          FN_SRL:  ctl_o.op = ALU_SRL;
          default: ctl_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctl_o.op       = ALU_ADD;
        ctl_o.use_imm  = 1'b1;
        ctl_o.sign_ext = 1'b1;
      end
      OPC_SLTI: begin
        ctl_o.op       = ALU_SLT;
        ctl_o.use_imm  = 1'b1;
        ctl_o.sign_ext = 1'b1;
      end
      OPC_ANDI: begin
        ctl_o.op      = ALU_AND;
        ctl_o.use_imm = 1'b1;
      end
      OPC_ORI: begin
        ctl_o.op      = ALU_OR;
        ctl_o.use_imm = 1'b1;
      end
      default: ctl_o.legal = 1'b0;
    endcase
    ctl_o.dst = reg_form ? rd_i : rt_i;
  end
endmodule

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
(
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  reg_b_i,
  input  logic             use_imm_i,
  input  logic             sign_ext_i,
  output logic [XLEN-1:0]  opnd_b_o
);
  localparam int EXT_W = XLEN - IMM_W;
  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext  = {{EXT_W{sign_ext_i & imm_i[IMM_W-1]}}, imm_i};
    opnd_b_o = use_imm_i ? imm_ext : reg_b_i;
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
(
  input  alu_op_e          op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [XLEN-1:0]  y_o
);
  logic [XLEN-1:0] diff;
  logic            less;

  always_comb begin
    diff = a_i - b_i;
    less = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN-1];
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = diff;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, less};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [31:0] src_a_i,
  input  logic [31:0] src_b_i,
  output logic [31:0] result_o,
  output logic [4:0]  dst_idx_o,
  output logic        wr_en_o,
  output logic        illegal_o
);
  exu_ctl_t        ctl;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_y;
  logic [SH_W-1:0] shamt;
  logic [RIDX_W-1:0] unused_rs;

  assign shamt     = instr_i[10:6];
  assign unused_rs = instr_i[25:21];

  exu_decode u_dec (
    .opcode_i (instr_i[31:26]),
    .funct_i  (instr_i[5:0]),
    .rt_i     (instr_i[20:16]),
    .rd_i     (instr_i[15:11]),
    .ctl_o    (ctl)
  );

  exu_operand u_opnd (
    .imm_i      (instr_i[15:0]),
    .reg_b_i    (src_b_i),
    .use_imm_i  (ctl.use_imm),
    .sign_ext_i (ctl.sign_ext),
    .opnd_b_o   (opnd_b)
  );

  exu_alu u_alu (
    .op_i    (ctl.op),
    .a_i     (src_a_i),
    .b_i     (opnd_b),
    .shamt_i (shamt),
    .y_o     (alu_y)
  );

  always_comb begin
    result_o  = ctl.legal ? alu_y : '0;
    dst_idx_o = ctl.dst;
    wr_en_o   = ctl.legal && (ctl.dst != '0);
    illegal_o = !ctl.legal;
  end

  // Checks relating decode, operand and ALU outputs
  always_comb begin
    assert_no_write_r0_R11: assert (!(wr_en_o && dst_idx_o == '0))
      else $error("write enabled toward index 0");
    assert_illegal_quiet_R12: assert (!(illegal_o && (wr_en_o || result_o != '0)))
      else $error("illegal encoding still writes");
    assert_slt_bool_R9: assert (!(!illegal_o && ctl.op == ALU_SLT && result_o[XLEN-1:1] != '0))
      else $error("compare result not boolean");
    assert_sll_lowzero_R5: assert (!(ctl.op == ALU_SLL && ctl.legal &&
                                     (alu_y & ((32'd1 << shamt) - 32'd1)) != '0))
      else $error("left shift left ones in low bits");
    assert_srl_highzero_R6: assert (!(ctl.op == ALU_SRL && ctl.legal && shamt != '0 &&
                                      (alu_y >> (XLEN - int'(shamt))) != '0))
      else $error("right shift left ones in high bits");
    assert_zext_R8: assert (!(ctl.legal && ctl.use_imm && !ctl.sign_ext && ctl.op == ALU_AND &&
                              alu_y[XLEN-1:IMM_W] != '0))
      else $error("and-immediate upper half not cleared");
  end
endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dst;
    logic        we;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [31:0] instr, a, b;
  logic [31:0] result;
  logic [4:0]  dst_idx;
  logic        wr_en, illegal;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   driver_done = 0;
  bit   finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exu_core dut (
    .instr_i   (instr),
    .src_a_i   (a),
    .src_b_i   (b),
    .result_o  (result),
    .dst_idx_o (dst_idx),
    .wr_en_o   (wr_en),
    .illegal_o (illegal)
  );

  function automatic logic [31:0] rform(input int rs, input int rt, input int rd,
                                        input int sh, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] iform(input logic [5:0] opc, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb,
                      input logic [31:0] eres, input int edst, input bit ewe, input bit eill,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    instr = ins; a = va; b = vb;
    e.res = eres; e.dst = 5'(edst); e.we = ewe; e.ill = eill; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (result !== e.res || dst_idx !== e.dst || wr_en !== e.we || illegal !== e.ill) begin
          errors++;
          $display("FAIL %s: got res=%h dst=%0d we=%0b ill=%0b, expected res=%h dst=%0d we=%0b ill=%0b",
                   e.tag, result, dst_idx, wr_en, illegal, e.res, e.dst, e.we, e.ill);
        end
      end else if (driver_done && !finished) begin
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Driver
  initial begin
    instr = '0; a = '0; b = '0;
    // reset-like idle state: all-zero word is a shift of register 0 into index 0
    send(32'h0, 32'h0, 32'h0, 32'h0, 0, 0, 0, "R5 idle word");
    // R1 add with wrap
    send(rform(1, 2, 3, 0, 6'h20), 32'hFFFF_FFFF, 32'h2, 32'h1, 3, 1, 0, "R1 wrap");
    send(rform(4, 5, 6, 7, 6'h20), 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 6, 1, 0, "R1 shamt ignored");
    // R2 sub
    send(rform(1, 2, 9, 0, 6'h22), 32'h0, 32'h1, 32'hFFFF_FFFF, 9, 1, 0, "R2 borrow");
    send(rform(1, 2, 9, 0, 6'h22), 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 9, 1, 0, "R2 wrap");
    // R3 and / or
    send(rform(1, 2, 10, 0, 6'h24), 32'hF0F0_FF00, 32'h3C3C_0FF0, 32'hF0F0_FF00 & 32'h3C3C_0FF0, 10, 1, 0, "R3 and");
    send(rform(1, 2, 11, 0, 6'h25), 32'hF0F0_0000, 32'h0000_0F0F, 32'hF0F0_0F0F, 11, 1, 0, "R3 or");
    // R4 nor and NOT
    send(rform(1, 2, 12, 0, 6'h27), 32'hA5A5_0000, 32'h0000_5A5A, ~(32'hA5A5_5A5A), 12, 1, 0, "R4 nor");
    send(rform(1, 0, 12, 0, 6'h27), 32'h0F0F_1234, 32'h0, ~32'h0F0F_1234, 12, 1, 0, "R4 not");
    // R5 left shift
    send(rform(0, 2, 13, 31, 6'h00), 32'h0, 32'h0000_0003, 32'h8000_0000, 13, 1, 0, "R5 by 31");
    send(rform(0, 2, 13, 4, 6'h00), 32'h0, 32'h0000_0005, 32'h0000_0050, 13, 1, 0, "R5 times 16");
    // R6 right shift logical
    send(rform(0, 2, 14, 31, 6'h02), 32'h0, 32'h8000_0000, 32'h1, 14, 1, 0, "R6 by 31");
    send(rform(0, 2, 14, 4, 6'h02), 32'h0, 32'hF000_0000, 32'h0F00_0000, 14, 1, 0, "R6 zero fill");
    // R7 add immediate with sign extension (b ignored)
    send(iform(6'h08, 1, 15, 16'hFFFF), 32'h0000_0010, 32'hDEAD_BEEF, 32'h0000_000F, 15, 1, 0, "R7 minus one");
    send(iform(6'h08, 1, 15, 16'h7FFF), 32'hFFFF_FFFF, 32'h0, 32'h0000_7FFE, 15, 1, 0, "R7 max positive");
    // R8 zero-extended logic immediates
    send(iform(6'h0C, 1, 16, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 16, 1, 0, "R8 andi");
    send(iform(6'h0D, 1, 17, 16'h8000), 32'h1200_0001, 32'h0, 32'h1200_8001, 17, 1, 0, "R8 ori");
    // R9 signed set-less-than-immediate
    send(iform(6'h0A, 1, 18, 16'hFFFF), 32'hFFFF_FFFB, 32'h0, 32'h1, 18, 1, 0, "R9 -5 < -1");
    send(iform(6'h0A, 1, 18, 16'hFFFF), 32'h0000_0005, 32'h0, 32'h0, 18, 1, 0, "R9 5 < -1");
    send(iform(6'h0A, 1, 18, 16'h0007), 32'h0000_0007, 32'h0, 32'h0, 18, 1, 0, "R9 equal");
    send(iform(6'h0A, 1, 18, 16'h0001), 32'h8000_0000, 32'h0, 32'h1, 18, 1, 0, "R9 most negative");
    // R10 destination field selection (rd field holds different value)
    send(iform(6'h08, 1, 21, 16'h3800), 32'h0, 32'h0, 32'h0000_3800, 21, 1, 0, "R10 I takes rt");
    send(rform(1, 21, 7, 0, 6'h20), 32'h1, 32'h1, 32'h2, 7, 1, 0, "R10 R takes rd");
    // R11 index 0 suppresses write-back
    send(rform(1, 2, 0, 0, 6'h20), 32'h5, 32'h6, 32'hB, 0, 0, 0, "R11 rd zero");
    send(iform(6'h0D, 1, 0, 16'h00F0), 32'h0, 32'h0, 32'h0000_00F0, 0, 0, 0, "R11 rt zero");
    // R12 illegal encodings
    send(iform(6'h3F, 1, 2, 16'h1234), 32'h5, 32'h6, 32'h0, 2, 0, 1, "R12 bad opcode");
    send(rform(1, 2, 3, 0, 6'h01), 32'h5, 32'h6, 32'h0, 3, 0, 1, "R12 bad funct");
    send(rform(1, 2, 3, 0, 6'h2A), 32'h5, 32'h6, 32'h0, 3, 0, 1, "R12 reg compare unsupported");
    // recovery after illegal
    send(rform(1, 2, 3, 0, 6'h20), 32'h5, 32'h6, 32'hB, 3, 1, 0, "R1 after illegal");
    driver_done = 1;
  end
endmodule